// File: doc/BRIEF.md
# Register Bank with Special and Guarded Registers

This block is the architectural register storage of a small 32-bit processor core. It holds sixteen general-purpose words and a set of named special registers behind a single 5-bit register specifier. Two combinational read ports and one clocked write port serve the execute stage. The current privilege level and the live program-counter value come in as inputs.

Each access is checked against the kind of register it names. Five kinds are handled:

- A hardwired zero register.
- A program-counter view that can only be read.
- Two registers reserved for kernel mode: the interrupt table base and the memory map.
- A range of placeholder specifiers that may never be touched.
- Plain read/write registers.

An illegal access is blocked. One clock later the block raises a single-cycle fault pulse with a cause code. Decoding that cause is left to the core's exception logic.

Specifier map:

| Codes | Register |
|---|---|
| 0..15 | general registers |
| 16 | accumulator |
| 17 | stack pointer |
| 18 | frame base pointer |
| 19 | return link |
| 20 | zero |
| 21 | program-counter view |
| 22 | interrupt table base (kernel only) |
| 23 | memory map (kernel only) |
| 24..31 | placeholder (always illegal) |

Top module: `spec_regfile`

## Requirements
- R1: Codes 0..15 select sixteen independent 32-bit general registers. A word written through the write port is read back unchanged on either read port from the cycle after the write.
- R2: Reading code 20 returns 0. A write to code 20 changes nothing and raises no fault.
- R3: Reading code 21 returns the `pcValue` input. A write to code 21 is blocked and raises fault cause 3.
- R4: Codes 22 and 23 can be read and written when `kernelMode` is 1. When `kernelMode` is 0, an access to either is blocked, a read returns 0, and fault cause 2 is raised.
- R5: Any enabled access, read or write, to codes 24..31 raises fault cause 1. Such a read returns 0 and such a write changes nothing.
- R6: Codes 16..19 (accumulator, stack pointer, frame base, return link) are ordinary read/write 32-bit registers.
- R7: After reset, every writable register reads 0 and `fault` is 0 with `faultCause` 0.
- R8: When a read port and the write port name the same register in one cycle, the read returns the value held before the write.
- R9: `fault` is registered. It is high for exactly the one cycle after a cycle containing an illegal enabled access; otherwise it is 0. An access on a port whose enable is low never faults.
- R10: When several ports are illegal in the same cycle, `faultCause` reports the lowest nonzero code (1 before 2 before 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| kernelMode | input | 1 | 1 when the core runs in kernel mode |
| pcValue | input | 32 | Live program-counter value shown at code 21 |
| rdEnA | input | 1 | Read port A enable |
| rdSelA | input | 5 | Read port A specifier |
| rdDataA | output | 32 | Read port A data (combinational) |
| rdEnB | input | 1 | Read port B enable |
| rdSelB | input | 5 | Read port B specifier |
| rdDataB | output | 32 | Read port B data (combinational) |
| wrEn | input | 1 | Write port enable |
| wrSel | input | 5 | Write port specifier |
| wrData | input | 32 | Write data |
| fault | output | 1 | One-cycle fault pulse, registered |
| faultCause | output | 2 | 0 none, 1 placeholder, 2 privilege, 3 program-counter write |

## Verification
The bench targets the guarded specifiers first:

- **Zero register write.** A design that stored the write would later read back nonzero; one that flagged it would pulse `fault`.
- **Program-counter write.** A design that let it through, or missed the cause, shows a wrong `faultCause`.
- **User-mode access to a kernel register.** A design that failed to block it leaks the stored word or corrupts it; the bench then reads the register back in kernel mode.
- **Disabled port holding a placeholder code.** A design that ignored the enable would fault spuriously.

The bench also targets timing and ordering:

- **Read and write to the same register in one cycle.** A bypassing design returns the new word instead of the old one.
- **Simultaneous illegal accesses.** A design with the wrong priority reports cause 3 where cause 1 is due.
- **Fault pulse length.** A design that held the fault high would still show it on the following idle cycle.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int SEL_W = 5;
  localparam int NUM_GPR = 16;

  localparam logic [SEL_W-1:0] SEL_ACC   = 5'd16;
  localparam logic [SEL_W-1:0] SEL_STK   = 5'd17;
  localparam logic [SEL_W-1:0] SEL_BASE  = 5'd18;
  localparam logic [SEL_W-1:0] SEL_LINK  = 5'd19;
  localparam logic [SEL_W-1:0] SEL_ZERO  = 5'd20;
  localparam logic [SEL_W-1:0] SEL_PC    = 5'd21;
  localparam logic [SEL_W-1:0] SEL_IVT   = 5'd22;
  localparam logic [SEL_W-1:0] SEL_MAP   = 5'd23;
  localparam logic [SEL_W-1:0] SEL_BAD_LO = 5'd24;

  // Lower code wins when several ports are illegal together
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_NOREG = 2'd1,
    CAUSE_PRIV  = 2'd2,
    CAUSE_PCWR  = 2'd3
  } cause_e;

  typedef struct packed {
    logic             wrCommit;
    logic [SEL_W-1:0] wrIdx;
    logic             rdMaskA;
    logic             rdMaskB;
  } strobes_t;
endpackage

// File: rtl/regfile_ctrl.sv
module regfile_ctrl
  import regfile_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             kernelMode,
  input  logic             rdEnA,
  input  logic [SEL_W-1:0] rdSelA,
  input  logic             rdEnB,
  input  logic [SEL_W-1:0] rdSelB,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  output strobes_t         strb,
  output logic             fault,
  output logic [1:0]       faultCause
);
  cause_e causeA, causeB, causeW, causeRd, causeAll;
  cause_e causeQ;
  logic   faultQ;

  function automatic cause_e classify(input logic en, input logic [SEL_W-1:0] sel,
                                      input logic km, input logic isWrite);
    cause_e c;
    c = CAUSE_NONE;
    if (en) begin
      if (sel >= SEL_BAD_LO)                         c = CAUSE_NOREG;
      else if ((sel == SEL_IVT || sel == SEL_MAP) && !km) c = CAUSE_PRIV;
      else if (isWrite && sel == SEL_PC)             c = CAUSE_PCWR;
    end
    return c;
  endfunction

  function automatic cause_e pickCause(input cause_e a, input cause_e b);
    if (a == CAUSE_NONE) return b;
    if (b == CAUSE_NONE) return a;
    return (a < b) ? a : b;
  endfunction

  always_comb begin
    causeA   = classify(rdEnA, rdSelA, kernelMode, 1'b0);
    causeB   = classify(rdEnB, rdSelB, kernelMode, 1'b0);
    causeW   = classify(wrEn, wrSel, kernelMode, 1'b1);
    causeRd  = pickCause(causeA, causeB);
    causeAll = pickCause(causeRd, causeW);

    strb.rdMaskA  = (causeA != CAUSE_NONE) || (rdSelA == SEL_ZERO);
    strb.rdMaskB  = (causeB != CAUSE_NONE) || (rdSelB == SEL_ZERO);
    strb.wrIdx    = wrSel;
    strb.wrCommit = wrEn && (causeW == CAUSE_NONE) && (wrSel != SEL_ZERO) && (wrSel != SEL_PC);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultQ <= 1'b0;
      causeQ <= CAUSE_NONE;
    end else begin
      faultQ <= (causeAll != CAUSE_NONE);
      causeQ <= causeAll;
    end
  end

  assign fault      = faultQ;
  assign faultCause = causeQ;

  assert_noreg_fault_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel >= SEL_BAD_LO) |=> (fault && faultCause == CAUSE_NOREG));

  assert_priv_block_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !kernelMode && (wrSel == SEL_IVT || wrSel == SEL_MAP)) |-> !strb.wrCommit);

  assert_pc_never_written_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == SEL_PC) |-> !strb.wrCommit);

  assert_zero_silent_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == SEL_ZERO && !rdEnA && !rdEnB) |=> !fault);

  assert_fault_has_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (faultCause != CAUSE_NONE));
endmodule

// File: rtl/regfile_dp.sv
module regfile_dp
  import regfile_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobes_t                  strb,
  input  logic [XLEN-1:0]           pcValue,
  input  logic [1:0][SEL_W-1:0]     rdSel,
  input  logic [XLEN-1:0]           wrData,
  output logic [1:0][XLEN-1:0]      rdData
);
  localparam int NUM_SLOTS = 1 << SEL_W;

  logic [XLEN-1:0] slots [NUM_SLOTS];
  logic [1:0]      rdMask;

  assign rdMask = {strb.rdMaskB, strb.rdMaskA};

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (!rstN)
        slots[i] <= '0;
      else if (strb.wrCommit && strb.wrIdx == SEL_W'(i))
        slots[i] <= wrData;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rdPort
    always_comb begin
      if (rdMask[p])              rdData[p] = '0;
      else if (rdSel[p] == SEL_PC) rdData[p] = pcValue;
      else                        rdData[p] = slots[rdSel[p]];
    end
  end

  assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCommit |=> (slots[$past(strb.wrIdx)] == $past(wrData)));
endmodule

// File: rtl/spec_regfile.sv
module spec_regfile
  import regfile_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             kernelMode,
  input  logic [XLEN-1:0]  pcValue,
  input  logic             rdEnA,
  input  logic [4:0]       rdSelA,
  output logic [XLEN-1:0]  rdDataA,
  input  logic             rdEnB,
  input  logic [4:0]       rdSelB,
  output logic [XLEN-1:0]  rdDataB,
  input  logic             wrEn,
  input  logic [4:0]       wrSel,
  input  logic [XLEN-1:0]  wrData,
  output logic             fault,
  output logic [1:0]       faultCause
);
  strobes_t                  strb;
  logic [1:0][SEL_W-1:0]     rdSelPair;
  logic [1:0][XLEN-1:0]      rdDataPair;

  assign rdSelPair = {rdSelB, rdSelA};
  assign rdDataA   = rdDataPair[0];
  assign rdDataB   = rdDataPair[1];

  regfile_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .kernelMode(kernelMode),
    .rdEnA(rdEnA), .rdSelA(rdSelA), .rdEnB(rdEnB), .rdSelB(rdSelB),
    .wrEn(wrEn), .wrSel(wrSel), .strb(strb),
    .fault(fault), .faultCause(faultCause)
  );

  regfile_dp #(.XLEN(XLEN)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pcValue(pcValue),
    .rdSel(rdSelPair), .wrData(wrData), .rdData(rdDataPair)
  );
endmodule

// File: tb/tb_spec_regfile.sv
module tb_spec_regfile;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        kernelMode = 1'b0;
  logic [31:0] pcValue = 32'hCAFE_0100;
  logic        rdEnA = 1'b0, rdEnB = 1'b0, wrEn = 1'b0;
  logic [4:0]  rdSelA = '0, rdSelB = '0, wrSel = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdDataA, rdDataB;
  logic        fault;
  logic [1:0]  faultCause;

  int total = 0;
  int bad = 0;
  logic [31:0] gotA, gotB;
  logic        gotFault;
  logic [1:0]  gotCause;

  always #2 clk = ~clk;

  spec_regfile dut (
    .clk(clk), .rstN(rstN), .kernelMode(kernelMode), .pcValue(pcValue),
    .rdEnA(rdEnA), .rdSelA(rdSelA), .rdDataA(rdDataA),
    .rdEnB(rdEnB), .rdSelB(rdSelB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .fault(fault), .faultCause(faultCause)
  );

  // {write specifier, data}; reads expect data, except code 20 which reads 0
  localparam logic [36:0] VEC [10] = '{
    {5'd0,  32'h1111_0000}, {5'd5,  32'hA5A5_5A5A}, {5'd15, 32'hFFFF_FFFF},
    {5'd9,  32'h0000_0001}, {5'd16, 32'h1234_5678}, {5'd17, 32'h0001_0000},
    {5'd18, 32'h0000_FFF0}, {5'd19, 32'hDEAD_BEEF}, {5'd20, 32'h7777_7777},
    {5'd1,  32'h8000_0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic ea, input logic [4:0] sa, input logic eb,
                        input logic [4:0] sb, input logic ew, input logic [4:0] sw,
                        input logic [31:0] dw);
    rdEnA = ea; rdSelA = sa; rdEnB = eb; rdSelB = sb;
    wrEn = ew; wrSel = sw; wrData = dw;
    #1;
    gotA = rdDataA; gotB = rdDataB;
    @(posedge clk); #1;
    gotFault = fault; gotCause = faultCause;
    rdEnA = 0; rdEnB = 0; wrEn = 0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 20000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R7 reset state
    check("R7 fault after reset", {31'd0, fault}, 32'd0);
    check("R7 cause after reset", {30'd0, faultCause}, 32'd0);
    for (int s = 0; s < 20; s += 2) begin
      access(1, 5'(s), 1, 5'(s + 1), 0, 0, 0);
      check("R7 reset value A", gotA, 32'd0);
      check("R7 reset value B", gotB, 32'd0);
    end

    // R1 R2 R6 vector table: write then read on both ports
    for (int i = 0; i < 10; i++) begin
      logic [4:0]  sel;
      logic [31:0] val, expv;
      sel  = VEC[i][36:32];
      val  = VEC[i][31:0];
      expv = (sel == 5'd20) ? 32'd0 : val;
      access(0, 0, 0, 0, 1, sel, val);
      check("R2 R6 no fault on legal write", {31'd0, gotFault}, 32'd0);
      access(1, sel, 1, sel, 0, 0, 0);
      check("R1 R6 readback A", gotA, expv);
      check("R1 R2 readback B", gotB, expv);
    end
    // R1 earlier writes survive later ones
    access(1, 5'd0, 1, 5'd5, 0, 0, 0);
    check("R1 r0 retained", gotA, 32'h1111_0000);
    check("R1 r5 retained", gotB, 32'hA5A5_5A5A);

    // R3 program counter view
    access(1, 5'd21, 0, 0, 0, 0, 0);
    check("R3 pc read", gotA, 32'hCAFE_0100);
    check("R3 pc read no fault", {31'd0, gotFault}, 32'd0);
    access(0, 0, 0, 0, 1, 5'd21, 32'h0BAD_0BAD);
    check("R3 pc write fault", {31'd0, gotFault}, 32'd1);
    check("R3 pc write cause", {30'd0, gotCause}, 32'd3);
    pcValue = 32'h0000_4444;
    access(1, 5'd21, 0, 0, 0, 0, 0);
    check("R3 pc follows input", gotA, 32'h0000_4444);
    check("R9 pulse ends", {31'd0, gotFault}, 32'd0);

    // R4 privileged registers
    kernelMode = 1'b0;
    access(0, 0, 0, 0, 1, 5'd22, 32'h5555_AAAA);
    check("R4 user write fault", {31'd0, gotFault}, 32'd1);
    check("R4 user write cause", {30'd0, gotCause}, 32'd2);
    kernelMode = 1'b1;
    access(1, 5'd22, 1, 5'd23, 0, 0, 0);
    check("R4 user write blocked", gotA, 32'd0);
    check("R4 kernel read no fault", {31'd0, gotFault}, 32'd0);
    access(0, 0, 0, 0, 1, 5'd23, 32'h0F0F_F0F0);
    check("R4 kernel write no fault", {31'd0, gotFault}, 32'd0);
    access(1, 5'd23, 0, 0, 0, 0, 0);
    check("R4 kernel readback", gotA, 32'h0F0F_F0F0);
    kernelMode = 1'b0;
    access(0, 0, 1, 5'd23, 0, 0, 0);
    check("R4 user read zero", gotB, 32'd0);
    check("R4 user read cause", {30'd0, gotCause}, 32'd2);

    // R5 placeholder codes
    access(0, 0, 1, 5'd31, 0, 0, 0);
    check("R5 placeholder read zero", gotB, 32'd0);
    check("R5 placeholder read fault", {31'd0, gotFault}, 32'd1);
    check("R5 placeholder read cause", {30'd0, gotCause}, 32'd1);
    access(0, 0, 0, 0, 1, 5'd26, 32'h9999_9999);
    check("R5 placeholder write cause", {30'd0, gotCause}, 32'd1);

    // R9 disabled port never faults
    rdSelA = 5'd31; wrSel = 5'd21;
    access(0, 5'd31, 0, 5'd24, 0, 5'd21, 0);
    check("R9 disabled ports no fault", {31'd0, gotFault}, 32'd0);

    // R10 priority: pc write (3) with placeholder read (1) and user priv read (2)
    access(1, 5'd31, 1, 5'd22, 1, 5'd21, 32'h1);
    check("R10 priority cause", {30'd0, gotCause}, 32'd1);
    access(0, 0, 1, 5'd22, 1, 5'd21, 32'h1);
    check("R10 priority priv over pc", {30'd0, gotCause}, 32'd2);

    // R8 same-cycle read/write returns old value
    access(1, 5'd5, 1, 5'd5, 1, 5'd5, 32'hBEEF_0005);
    check("R8 old value A", gotA, 32'hA5A5_5A5A);
    check("R8 old value B", gotB, 32'hA5A5_5A5A);
    access(1, 5'd5, 0, 0, 0, 0, 0);
    check("R8 new value after", gotA, 32'hBEEF_0005);

    // R7 reset mid-run clears state
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    access(1, 5'd5, 1, 5'd19, 0, 0, 0);
    check("R7 rereset r5", gotA, 32'd0);
    check("R7 rereset link", gotB, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule